// File: doc/BRIEF.md
# Two-Class Virtual-Channel Link Multiplexer

This block lets several virtual channels share one physical output link. The channels are split into two equal halves. The lower half carries best-effort traffic and the upper half carries constant-bit-rate traffic. Every channel has its own flit queue, filled through its own valid/ready enqueue port. Every channel also has its own credit counter, which mirrors the free buffer slots that the downstream router keeps for that channel. The two traffic classes therefore compete only for link cycles and never for buffer space.

In each cycle, a channel is eligible when it holds at least one queued flit and at least one credit. Inside each class, a round-robin arbiter picks one eligible channel. Between the two classes, the preferred class flips on every cycle. The winning flit appears on the registered link outputs one cycle later, together with the index of its channel. The downstream router returns credits as single-cycle pulses, each tagged with a channel index.

Top module: `vc_link_mux`

## Requirements
- R1: After reset, `linkValid` is low and every `inReady` bit is high. Every credit counter starts at CREDIT_DEPTH.
- R2: Flits of one channel leave the link in the order they were accepted. Only accepted flits ever leave.
- R3: A channel's `inReady` is low while its queue holds QUEUE_DEPTH flits. A flit offered while `inReady` is low is discarded. `inReady` rises again once a flit of that channel has been sent.
- R4: A channel sends at most as many flits as it holds credits. A channel with zero credits sends nothing, however many flits it holds.
- R5: A pulse on `creditValid` adds one credit only to the channel named by `creditVc`. That allows exactly one more flit from that channel.
- R6: At most one flit is sent per cycle. `linkVc` carries the index of the channel the flit came from.
- R7: Inside a class, eligible channels are served in round-robin order. While all channels of a class stay eligible, the same channel is never picked twice in a row.
- R8: While both classes have eligible channels in consecutive cycles, the class that wins the link alternates from one cycle to the next.
- R9: Channels 0 to NUM_VC/2-1 form the best-effort class and the rest form the constant-bit-rate class. A stalled class never slows the other: a lone eligible channel sends one flit every cycle.
- R10: A credit that arrives while the channel already holds CREDIT_DEPTH credits is ignored.
- R11: A flit accepted at one clock edge can be on the link registers after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_VC | Per-channel enqueue request |
| inData | input | NUM_VC*FLIT_W | Per-channel flit, channel v in bits v*FLIT_W +: FLIT_W |
| inReady | output | NUM_VC | Per-channel queue has room |
| creditValid | input | 1 | One credit returned this cycle |
| creditVc | input | $clog2(NUM_VC) | Channel that the returned credit belongs to |
| linkValid | output | 1 | A flit is on the link this cycle |
| linkFlit | output | FLIT_W | Flit on the link |
| linkVc | output | $clog2(NUM_VC) | Channel index of the flit on the link |

## Verification
Some situations only arise after a channel has used up all its credits: a full queue refusing a flit, a stalled class sitting beside a busy one, and a surplus credit being dropped. The bench reaches them by first draining every channel's credits with a burst in which all channels are loaded at once. It then returns credits one pulse at a time. The same burst keeps both classes eligible on every cycle, so the log of link tags shows the class alternation and the round-robin order directly. Flits carry their channel number and a sequence count, so the scoreboard shows both a discarded flit and a misrouted one.

// File: rtl/vcmux_pkg.sv
package vcmux_pkg;
  localparam int MaxVcW = 6;

  typedef enum logic {
    NetBe  = 1'b0,
    NetCbr = 1'b1
  } netSel_e;

  typedef struct packed {
    logic              send;
    netSel_e           net;
    logic [MaxVcW-1:0] vc;
  } sendStrobe_t;
endpackage

// File: rtl/vcmux_ctrl.sv
module vcmux_ctrl
  import vcmux_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_VC-1:0] eligible,
  output sendStrobe_t       strb
);
  localparam int HALF = NUM_VC / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          prioCbr;
  logic          useCbr;
  logic [HW-1:0] winIdx;
  logic          bothNow;

  generate
    for (genvar n = 0; n < 2; n++) begin : g_net
      localparam netSel_e MyNet = (n == 1) ? NetCbr : NetBe;
      logic [HALF-1:0] req;
      logic            hit;
      logic [HW-1:0]   idx;
      logic [HW-1:0]   rrPtr;

      assign req = eligible[n*HALF +: HALF];

      // walk from the largest offset down so the nearest requester after the pointer wins
      always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int off = HALF; off >= 1; off--) begin
          if (req[(int'(rrPtr) + off) % HALF]) begin
            hit = 1'b1;
            idx = HW'((int'(rrPtr) + off) % HALF);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) rrPtr <= HW'(HALF - 1);
        else if (strb.send && strb.net == MyNet) rrPtr <= idx;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prioCbr <= 1'b0;
    else       prioCbr <= ~prioCbr;
  end

  always_comb begin
    useCbr    = prioCbr ? g_net[1].hit : (!g_net[0].hit && g_net[1].hit);
    winIdx    = useCbr ? g_net[1].idx : g_net[0].idx;
    strb      = '0;
    strb.send = g_net[0].hit | g_net[1].hit;
    strb.net  = useCbr ? NetCbr : NetBe;
    strb.vc   = MaxVcW'(useCbr ? HALF + int'(winIdx) : int'(winIdx));
  end

  assign bothNow = g_net[0].hit & g_net[1].hit;

  // R8
  net_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bothNow && $past(bothNow)) |-> (strb.net != $past(strb.net)));

  // R6
  vc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.send |-> (int'(strb.vc) < NUM_VC));
endmodule

// File: rtl/vcmux_datapath.sv
module vcmux_datapath
  import vcmux_pkg::*;
#(
  parameter int NUM_VC       = 4,
  parameter int VC_W         = 2,
  parameter int FLIT_W       = 16,
  parameter int QUEUE_DEPTH  = 4,
  parameter int CREDIT_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_VC-1:0]        inValid,
  input  logic [NUM_VC*FLIT_W-1:0] inData,
  output logic [NUM_VC-1:0]        inReady,
  input  logic                     creditValid,
  input  logic [VC_W-1:0]          creditVc,
  input  sendStrobe_t              strb,
  output logic [NUM_VC-1:0]        eligible,
  output logic                     linkValid,
  output logic [FLIT_W-1:0]        linkFlit,
  output logic [VC_W-1:0]          linkVc
);
  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);
  localparam int CRD_W = $clog2(CREDIT_DEPTH + 1);
  localparam int HALF  = NUM_VC / 2;

  logic [VC_W-1:0]   sendVc;
  logic [FLIT_W-1:0] headData [NUM_VC];

  assign sendVc = strb.vc[VC_W-1:0];

  generate
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      localparam logic [VC_W-1:0] MyIdx = VC_W'(v);
      logic [FLIT_W-1:0] mem [QUEUE_DEPTH];
      logic [PTR_W-1:0]  rdPtr, wrPtr;
      logic [CNT_W-1:0]  count;
      logic [CRD_W-1:0]  credit;
      logic              push, pop, ret;

      assign inReady[v]  = (count != CNT_W'(QUEUE_DEPTH));
      assign push        = inValid[v] & inReady[v];
      assign pop         = strb.send && (sendVc == MyIdx);
      assign ret         = creditValid && (creditVc == MyIdx) && (credit != CRD_W'(CREDIT_DEPTH));
      assign eligible[v] = (count != '0) && (credit != '0);
      assign headData[v] = mem[rdPtr];

      always_ff @(posedge clk) begin
        if (push) mem[wrPtr] <= inData[v*FLIT_W +: FLIT_W];
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdPtr  <= '0;
          wrPtr  <= '0;
          count  <= '0;
          credit <= CRD_W'(CREDIT_DEPTH);
        end else begin
          if (push) wrPtr <= (wrPtr == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
          if (pop)  rdPtr <= (rdPtr == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
          count  <= count + CNT_W'(push) - CNT_W'(pop);
          credit <= credit + CRD_W'(ret) - CRD_W'(pop);
        end
      end

      // R4
      pop_needs_credit_chk: assert property (@(posedge clk) disable iff (!rstN)
        pop |-> (credit != '0));

      // R2
      pop_needs_flit_chk: assert property (@(posedge clk) disable iff (!rstN)
        pop |-> (count != '0));

      // R10
      credit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
        credit <= CRD_W'(CREDIT_DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkFlit  <= '0;
      linkVc    <= '0;
    end else begin
      linkValid <= strb.send;
      if (strb.send) begin
        linkFlit <= headData[sendVc];
        linkVc   <= sendVc;
      end
    end
  end

  // R9
  net_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.send |-> ((strb.net == NetCbr) == (int'(strb.vc) >= HALF)));
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux
  import vcmux_pkg::*;
#(
  parameter int NUM_VC       = 4,
  parameter int FLIT_W       = 16,
  parameter int QUEUE_DEPTH  = 4,
  parameter int CREDIT_DEPTH = 4,
  localparam int VC_W        = $clog2(NUM_VC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_VC-1:0]        inValid,
  input  logic [NUM_VC*FLIT_W-1:0] inData,
  output logic [NUM_VC-1:0]        inReady,
  input  logic                     creditValid,
  input  logic [VC_W-1:0]          creditVc,
  output logic                     linkValid,
  output logic [FLIT_W-1:0]        linkFlit,
  output logic [VC_W-1:0]          linkVc
);
  sendStrobe_t       strb;
  logic [NUM_VC-1:0] eligible;

  vcmux_ctrl #(
    .NUM_VC(NUM_VC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .eligible(eligible),
    .strb    (strb)
  );

  vcmux_datapath #(
    .NUM_VC      (NUM_VC),
    .VC_W        (VC_W),
    .FLIT_W      (FLIT_W),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .CREDIT_DEPTH(CREDIT_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inData     (inData),
    .inReady    (inReady),
    .creditValid(creditValid),
    .creditVc   (creditVc),
    .strb       (strb),
    .eligible   (eligible),
    .linkValid  (linkValid),
    .linkFlit   (linkFlit),
    .linkVc     (linkVc)
  );
endmodule

// File: tb/vc_link_mux_tb.sv
module vc_link_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVC = 4;
  localparam int FW  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NVC-1:0]  inValid = '0;
  logic [NVC*FW-1:0] inData = '0;
  logic [NVC-1:0]  inReady;
  logic            creditValid = 1'b0;
  logic [1:0]      creditVc = '0;
  logic            linkValid;
  logic [FW-1:0]   linkFlit;
  logic [1:0]      linkVc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seqN    [NVC];
  int sentCnt [NVC];
  int logVc   [256];
  int logCyc  [256];
  int logN = 0;
  logic [FW-1:0] expQ [NVC][$];

  vc_link_mux u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .creditValid(creditValid), .creditVc(creditVc),
    .linkValid(linkValid), .linkFlit(linkFlit), .linkVc(linkVc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] flitWord(input int vc, input int seq);
    return {4'(vc), 12'(seq)};
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    logic [FW-1:0] expd;
    if (rstN && linkValid) begin
      if (expQ[linkVc].size() == 0) begin
        check(0, "R2 flit with nothing pending", int'(linkFlit), -1);
      end else begin
        expd = expQ[linkVc].pop_front();
        check(expd == linkFlit, "R2 flit order", int'(linkFlit), int'(expd));
      end
      // R6 tag matches channel encoded in flit
      check(linkFlit[15:12] == 4'(linkVc), "R6 vc tag", int'(linkVc), int'(linkFlit[15:12]));
      sentCnt[linkVc]++;
      if (logN < 256) begin
        logVc[logN]  = int'(linkVc);
        logCyc[logN] = cyc;
        logN++;
      end
    end
  end

  task automatic pushCycle(input logic [NVC-1:0] mask, output logic [NVC-1:0] acc);
    @(negedge clk);
    acc = '0;
    for (int v = 0; v < NVC; v++) begin
      if (mask[v]) begin
        inValid[v] = 1'b1;
        inData[v*FW +: FW] = flitWord(v, seqN[v]);
        if (inReady[v]) begin
          expQ[v].push_back(flitWord(v, seqN[v]));
          seqN[v]++;
          acc[v] = 1'b1;
        end
      end
    end
    @(posedge clk);
    #1 inValid = '0;
  endtask

  task automatic giveCredit(input int vc);
    @(negedge clk);
    creditValid = 1'b1;
    creditVc    = 2'(vc);
    @(posedge clk);
    #1 creditValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [NVC-1:0] acc;
    int base, s0, s1, s2, s3;
    int cnt [NVC];
    for (int v = 0; v < NVC; v++) begin seqN[v] = 0; sentCnt[v] = 0; end

    idle(3);
    @(negedge clk);
    // R1 reset state
    check(linkValid == 1'b0, "R1 linkValid in reset", int'(linkValid), 0);
    check(inReady == 4'hF, "R1 inReady in reset", int'(inReady), 15);
    rstN = 1'b1;
    @(negedge clk);
    check(linkValid == 1'b0, "R1 linkValid after reset", int'(linkValid), 0);
    check(inReady == 4'hF, "R1 inReady after reset", int'(inReady), 15);

    // burst: every channel loaded, both classes eligible every cycle
    base = logN;
    for (int i = 0; i < 4; i++) pushCycle(4'hF, acc);
    idle(24);
    check(logN - base == 16, "R1 credits per channel equal depth", logN - base, 16);
    for (int v = 0; v < NVC; v++) cnt[v] = 0;
    for (int i = 0; i < 8; i++) cnt[logVc[base+i]]++;
    for (int v = 0; v < NVC; v++)
      check(cnt[v] == 2, "R7 share in first eight sends", cnt[v], 2);
    for (int i = 0; i < 15; i++)
      check((logVc[base+i] >= 2) != (logVc[base+i+1] >= 2), "R8 class alternation",
            logVc[base+i+1], logVc[base+i]);
    for (int i = 0; i + 2 < 16; i++)
      check(logVc[base+i] != logVc[base+i+2], "R7 round-robin inside class",
            logVc[base+i+2], 99);

    // credits exhausted: VC0 stalls
    s0 = sentCnt[0];
    pushCycle(4'b0001, acc);
    pushCycle(4'b0001, acc);
    idle(10);
    check(sentCnt[0] == s0, "R4 no send without credit", sentCnt[0], s0);
    pushCycle(4'b0001, acc);
    pushCycle(4'b0001, acc);
    @(negedge clk);
    check(inReady[0] == 1'b0, "R3 ready low when full", int'(inReady[0]), 0);
    pushCycle(4'b0001, acc);
    check(acc == 4'b0000, "R3 offer refused while full", int'(acc), 0);
    s1 = sentCnt[1];
    giveCredit(0);
    idle(5);
    check(sentCnt[0] == s0 + 1, "R5 one credit one flit", sentCnt[0] - s0, 1);
    check(sentCnt[1] == s1, "R5 other channel untouched", sentCnt[1], s1);
    @(negedge clk);
    check(inReady[0] == 1'b1, "R3 ready back after send", int'(inReady[0]), 1);
    for (int i = 0; i < 3; i++) giveCredit(0);
    idle(6);
    check(sentCnt[0] == s0 + 4, "R3 only accepted flits sent", sentCnt[0] - s0, 4);

    // isolation: CBR stalled, BE channel streams
    s2 = sentCnt[2]; s3 = sentCnt[3];
    pushCycle(4'b1100, acc);
    pushCycle(4'b1100, acc);
    for (int i = 0; i < 4; i++) giveCredit(0);
    s0 = sentCnt[0];
    base = logN;
    for (int i = 0; i < 4; i++) pushCycle(4'b0001, acc);
    idle(8);
    check(sentCnt[0] == s0 + 4, "R9 BE sends while CBR stalled", sentCnt[0] - s0, 4);
    check(logN - base == 4, "R9 only BE on link", logN - base, 4);
    check(logCyc[base+3] - logCyc[base] == 3, "R9 one flit per cycle",
          logCyc[base+3] - logCyc[base], 3);
    check(sentCnt[2] == s2 && sentCnt[3] == s3, "R4 CBR held without credit",
          sentCnt[2] + sentCnt[3] - s2 - s3, 0);
    // R11: flit accepted at an edge is on the link after the next edge
    base = logN;
    pushCycle(4'b0001, acc);
    giveCredit(0);
    idle(4);
    check(logN - base == 1, "R11 single flit sent", logN - base, 1);
    base = logN;
    giveCredit(0);
    s0 = cyc;
    pushCycle(4'b0001, acc);
    idle(4);
    check(logN - base == 1 && logCyc[base] - s0 <= 2, "R11 latency", logCyc[base] - s0, 2);
    giveCredit(2); giveCredit(2); giveCredit(3); giveCredit(3);
    idle(6);
    check(sentCnt[2] == s2 + 2, "R5 CBR drain vc2", sentCnt[2] - s2, 2);
    check(sentCnt[3] == s3 + 2, "R5 CBR drain vc3", sentCnt[3] - s3, 2);

    // saturation: six credits to VC1 count as four
    for (int i = 0; i < 6; i++) giveCredit(1);
    s1 = sentCnt[1];
    for (int i = 0; i < 4; i++) pushCycle(4'b0010, acc);
    idle(8);
    pushCycle(4'b0010, acc);
    pushCycle(4'b0010, acc);
    idle(10);
    check(sentCnt[1] == s1 + 4, "R10 surplus credits dropped", sentCnt[1] - s1, 4);
    giveCredit(1); giveCredit(1);
    idle(6);
    check(sentCnt[1] == s1 + 6, "R5 drain vc1", sentCnt[1] - s1, 6);

    for (int v = 0; v < NVC; v++)
      check(expQ[v].size() == 0, "R2 all accepted flits delivered", expQ[v].size(), 0);
    finishRun();
  end
endmodule